// File: doc/BRIEF.md
# Brushless Motor Commutation and Gate Steering

This block produces six gate enables for a three-phase bridge: one upper and one lower transistor for each of phases A, B and C. In its commutation mode it reads three Hall sensor bits and a direction bit, and picks which phase is pulled high, which is pulled low and which is left floating. It then applies the PWM input with either two-quadrant or four-quadrant steering. A separate brake mode shorts the motor through the lower transistors. A select input can bypass all of this, so that six direct inputs each drive one transistor.

Every transistor change passes through a per-phase dead-time stage, so the two transistors of a phase are never on together. This also holds for the direct inputs. Three conditions remove all gate drive at once, with no clock delay: the disable input, an undervoltage-mode control input, and two supply comparator bits (one for the 5 V rail, one for the 15 V rail). The same comparator bits and the mode control input drive an active-low undervoltage flag.

Top module: `bldc_gate_steer`

## Requirements
- R1: While `rst_n` is low, all six gate outputs are 0.
- R2: The bit order is `gate[0]`=A upper, `gate[1]`=A lower, `gate[2]`=B upper, `gate[3]`=B lower, `gate[4]`=C upper, `gate[5]`=C lower. The Hall bits are `hall`={HA,HB,HC}. With `dir`=0, each valid code gives a pair (high phase, low phase), and the remaining phase floats: 101→(A,B), 100→(A,C), 110→(B,C), 010→(B,A), 011→(C,A), 001→(C,B).
- R3: With `dir`=1, the high and low phases of R2 swap for the same Hall code.
- R4: With `quad2`=1, the upper transistor of the high phase follows `pwm`. The lower transistor of the low phase is on steadily, and the lower transistor of the high phase stays off.
- R5: With `quad2`=0, the behaviour of R4 holds, and in addition the lower transistor of the high phase follows the inverse of `pwm`.
- R6: Hall codes 000 and 111 turn all six outputs off.
- R7: With `sel_int`=1 and `brake`=1, all upper outputs are off and all lower outputs follow `brake_pwm`. The Hall, `dir` and `pwm` inputs are then ignored. Upper outputs are off from the first clock edge after `brake` is seen high.
- R8: With `sel_int`=0, each `direct[i]` drives `gate[i]` (same bit order as R2). A phase whose upper and lower direct bits are both 1 is turned fully off. The Hall, `brake` and `pwm` inputs have no effect in this mode.
- R9: If `dis`, `uvm`, `uv5_low` or `uv15_low` is 1, all outputs are 0 in that same cycle, without waiting for a clock edge.
- R10: `uv_n` is 0 exactly when `uv5_low`, `uv15_low` or `uvm` is 1. `dis` has no effect on `uv_n`.
- R11: When an output of a phase turns off, both outputs of that phase stay off for `dead_cyc`+1 clock cycles before either one turns on again. The upper and lower outputs of a phase are never on in the same cycle.
- R12: Each Hall input passes through two synchronizer flops. A Hall change that removes an active output takes effect on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall | input | 3 | Hall sensor bits {HA,HB,HC}, asynchronous |
| dir | input | 1 | Rotation direction; 1 swaps the high and low phases |
| pwm | input | 1 | PWM input for commutation mode |
| quad2 | input | 1 | 1 = two-quadrant steering, 0 = four-quadrant steering |
| brake | input | 1 | Brake request (commutation mode only) |
| brake_pwm | input | 1 | Gating for the lower transistors during braking |
| sel_int | input | 1 | 1 = internal commutation, 0 = direct inputs |
| direct | input | 6 | Direct per-transistor requests |
| dis | input | 1 | Disable; 1 turns off all outputs |
| uvm | input | 1 | Undervoltage-mode control; 1 turns off all outputs and pulls the flag low |
| uv5_low | input | 1 | 5 V rail comparator, 1 = supply too low |
| uv15_low | input | 1 | 15 V rail comparator, 1 = supply too low |
| dead_cyc | input | DT_W | Dead time in clock cycles |
| gate | output | 6 | Gate enables |
| uv_n | output | 1 | Undervoltage flag, active low |

## Verification
The bench builds the block with the default `DT_W`=4. It runs the dead-time input at 0 and at 3. With 0, the one-cycle minimum gap and the exact Hall synchronizer latency can be seen cycle by cycle. With 3, a complementary handover in four-quadrant mode can be timed edge by edge, from the turn-off to the first cycle the opposite transistor is on. All twelve Hall/direction combinations are covered, together with both quadrant modes, braking, the direct path including the case where both bits of a phase are requested, and each shutdown source on its own.

// File: rtl/bldc_gate_steer.sv
module bldc_gate_steer #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      hall,
  input  logic            dir,
  input  logic            pwm,
  input  logic            quad2,
  input  logic            brake,
  input  logic            brake_pwm,
  input  logic            sel_int,
  input  logic [5:0]      direct,
  input  logic            dis,
  input  logic            uvm,
  input  logic            uv5_low,
  input  logic            uv15_low,
  input  logic [DT_W-1:0] dead_cyc,
  output logic [5:0]      gate,
  output logic            uv_n
);

  logic [2:0] h_s1, h_s2;
  logic [1:0] ph_a, ph_b, hi_ph, lo_ph;
  logic       h_ok;
  logic       kill;
  logic [5:0] want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_s1 <= 3'b000;
      h_s2 <= 3'b000;
    end else begin
      h_s1 <= hall;
      h_s2 <= h_s1;
    end
  end

  assign kill = dis | uvm | uv5_low | uv15_low;
  assign uv_n = ~(uv5_low | uv15_low | uvm);

  always_comb begin
    h_ok = 1'b1;
    ph_a = 2'd0;
    ph_b = 2'd0;
    case (h_s2)
      3'b101:  begin ph_a = 2'd0; ph_b = 2'd1; end
      3'b100:  begin ph_a = 2'd0; ph_b = 2'd2; end
      3'b110:  begin ph_a = 2'd1; ph_b = 2'd2; end
      3'b010:  begin ph_a = 2'd1; ph_b = 2'd0; end
      3'b011:  begin ph_a = 2'd2; ph_b = 2'd0; end
      3'b001:  begin ph_a = 2'd2; ph_b = 2'd1; end
      default: h_ok = 1'b0;
    endcase
  end

  assign hi_ph = dir ? ph_b : ph_a;
  assign lo_ph = dir ? ph_a : ph_b;

  always_comb begin
    want = 6'b000000;
    if (kill) begin
      want = 6'b000000;
    end else if (!sel_int) begin
      for (int p = 0; p < 3; p++)
        if (!(direct[2*p] && direct[2*p+1]))
          want[2*p +: 2] = direct[2*p +: 2];
    end else if (brake) begin
      want = {brake_pwm, 1'b0, brake_pwm, 1'b0, brake_pwm, 1'b0};
    end else if (h_ok) begin
      want[{hi_ph, 1'b0}] = pwm;
      if (!quad2) want[{hi_ph, 1'b1}] = ~pwm;
      want[{lo_ph, 1'b1}] = 1'b1;
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_phase
    logic [1:0]      st;
    logic [1:0]      w;
    logic [DT_W-1:0] cnt;

    assign w = want[2*p +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= 2'b00;
        cnt <= '0;
      end else if (st != 2'b00 && w != st) begin
        st  <= 2'b00;
        cnt <= dead_cyc;
      end else if (st == 2'b00) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        else           st  <= w;
      end
    end

    assign gate[2*p +: 2] = kill ? 2'b00 : st;
  end

endmodule

// File: rtl/bldc_gate_steer_chk.sv
module bldc_gate_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brake,
  input logic       sel_int,
  input logic       dis,
  input logic       uvm,
  input logic       uv5_low,
  input logic       uv15_low,
  input logic [5:0] gate,
  input logic       uv_n
);

  always @(posedge clk)
    if (!rst_n) a_reset_r1: assert (gate == 6'b000000);

  p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]) && !(gate[4] && gate[5]));

  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !((gate[1] && $past(gate[0])) || (gate[0] && $past(gate[1])) ||
      (gate[3] && $past(gate[2])) || (gate[2] && $past(gate[3])) ||
      (gate[5] && $past(gate[4])) || (gate[4] && $past(gate[5]))));

  p_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis || uvm || uv5_low || uv15_low) |-> gate == 6'b000000);

  p_flag_dis_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !uvm && !uv5_low && !uv15_low) |-> uv_n);

  p_flag_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uvm || uv5_low || uv15_low) |-> !uv_n);

  p_brake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brake && sel_int) |-> (!gate[0] && !gate[2] && !gate[4]));

endmodule

bind bldc_gate_steer bldc_gate_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brake(brake), .sel_int(sel_int), .dis(dis),
  .uvm(uvm), .uv5_low(uv5_low), .uv15_low(uv15_low), .gate(gate), .uv_n(uv_n)
);

// File: tb/bldc_gate_steer_tb_top.sv
module bldc_gate_steer_tb_top;
  localparam int CLK_NS = 10;
  localparam int DT_W   = 4;

  logic clk = 1'b0;
  logic rst_n, dir, pwm, quad2, brake, brake_pwm, sel_int, dis, uvm, uv5_low, uv15_low;
  logic [2:0] hall;
  logic [5:0] direct;
  logic [DT_W-1:0] dead_cyc;
  logic [5:0] gate;
  logic uv_n;

  always #(CLK_NS/2) clk = ~clk;

  bldc_gate_steer #(.DT_W(DT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir(dir), .pwm(pwm), .quad2(quad2),
    .brake(brake), .brake_pwm(brake_pwm), .sel_int(sel_int), .direct(direct),
    .dis(dis), .uvm(uvm), .uv5_low(uv5_low), .uv15_low(uv15_low),
    .dead_cyc(dead_cyc), .gate(gate), .uv_n(uv_n)
  );

  typedef struct {
    int         cyc;
    logic [5:0] g;
    logic       u;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      total++;
      if (gate !== e.g || uv_n !== e.u) begin
        bad++;
        $display("FAIL %s: gate=%h uv_n=%b expected gate=%h uv_n=%b", e.tag, gate, uv_n, e.g, e.u);
      end
    end
  end

  task automatic push(input int d, input logic [5:0] g, input logic u, input string tag);
    q.push_back('{cyc + d, g, u, tag});
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic steady(input logic [5:0] g, input logic u, input string tag);
    tick(24);
    push(1, g, u, tag);
    tick(2);
  endtask

  function automatic logic [5:0] model(input logic [2:0] h, input logic d);
    int hi, lo;
    logic [5:0] r;
    case (h)
      3'b101: begin hi = 0; lo = 1; end
      3'b100: begin hi = 0; lo = 2; end
      3'b110: begin hi = 1; lo = 2; end
      3'b010: begin hi = 1; lo = 0; end
      3'b011: begin hi = 2; lo = 0; end
      default: begin hi = 2; lo = 1; end
    endcase
    if (d) begin int t = hi; hi = lo; lo = t; end
    r = '0;
    r[2*hi] = 1'b1;
    r[2*lo+1] = 1'b1;
    return r;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [6];
    codes = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    rst_n = 0; hall = 3'b101; dir = 0; pwm = 1; quad2 = 1; brake = 0; brake_pwm = 0;
    sel_int = 1; direct = '0; dis = 0; uvm = 0; uv5_low = 0; uv15_low = 0; dead_cyc = '0;
    tick(2);
    push(1, 6'h00, 1'b1, "R1 reset");
    tick(3);
    rst_n = 1;

    for (int di = 0; di < 2; di++)
      for (int i = 0; i < 6; i++) begin
        hall = codes[i]; dir = di[0];
        steady(model(codes[i], di[0]), 1'b1, di == 0 ? "R2 forward table" : "R3 reversed table");
      end

    hall = 3'b101; dir = 0; pwm = 0; quad2 = 1;
    steady(6'h08, 1'b1, "R4 two-quadrant pwm low");
    quad2 = 0;
    steady(6'h0A, 1'b1, "R5 four-quadrant pwm low");
    pwm = 1;
    steady(6'h09, 1'b1, "R5 four-quadrant pwm high");

    dead_cyc = 4'd3;
    steady(6'h09, 1'b1, "R11 settle");
    pwm = 0;
    push(1, 6'h09, 1'b1, "R11 before edge");
    push(2, 6'h08, 1'b1, "R11 upper off");
    push(5, 6'h08, 1'b1, "R11 gap end");
    push(6, 6'h0A, 1'b1, "R11 lower on");
    tick(10);
    pwm = 1;
    push(2, 6'h08, 1'b1, "R11 lower off");
    push(5, 6'h08, 1'b1, "R11 gap end back");
    push(6, 6'h09, 1'b1, "R11 upper on");
    tick(10);

    dead_cyc = '0; quad2 = 1;
    steady(6'h09, 1'b1, "R12 settle");
    hall = 3'b000;
    push(3, 6'h09, 1'b1, "R12 still old after two edges");
    push(4, 6'h00, 1'b1, "R12 off on third edge");
    tick(8);
    steady(6'h00, 1'b1, "R6 hall 000");
    hall = 3'b111;
    steady(6'h00, 1'b1, "R6 hall 111");

    hall = 3'b101; brake = 1; brake_pwm = 1;
    steady(6'h2A, 1'b1, "R7 brake on");
    brake_pwm = 0;
    steady(6'h00, 1'b1, "R7 brake gated off");
    brake = 0;

    sel_int = 0; direct = 6'b100001;
    steady(6'h21, 1'b1, "R8 direct");
    direct = 6'b000011;
    steady(6'h00, 1'b1, "R8 both bits of phase");
    direct = 6'b011000; brake = 1; hall = 3'b000;
    steady(6'h18, 1'b1, "R8 brake and hall ignored");

    dis = 1;
    push(1, 6'h00, 1'b1, "R9 disable immediate, R10 flag unaffected");
    tick(2); dis = 0;
    steady(6'h18, 1'b1, "R9 recover");
    uvm = 1;
    push(1, 6'h00, 1'b0, "R9 R10 uvm");
    tick(2); uvm = 0;
    steady(6'h18, 1'b1, "R9 recover uvm");
    uv5_low = 1;
    push(1, 6'h00, 1'b0, "R9 R10 5V low");
    tick(2); uv5_low = 0;
    uv15_low = 1;
    push(1, 6'h00, 1'b0, "R9 R10 15V low");
    tick(2); uv15_low = 0;
    steady(6'h18, 1'b1, "R10 flag released");

    tick(5);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule